// File: doc/BRIEF.md
# Floating-Point Compare Condition Evaluator

This block decides the outcome of a floating-point compare. It takes two operands, single or double precision, and a 4-bit compare predicate. The predicate is the compare function code minus 48, so function codes 48 to 63 map to predicates 0 to 15. The block returns three things: a one-bit condition, an invalid-operation flag, and the index of the condition-code bit that the result is meant for. Operand fetch and the status register are outside the block. The surrounding pipeline reads the operands, strobes them in, and writes the condition into its own status word at the reported index.

The low three predicate bits form a mask over three mutually exclusive relations: unordered, equal and less-than. The condition is true when any relation in the mask holds. The top predicate bit selects a signalling compare, which flags invalid whenever the operands are unordered. A quiet compare flags invalid only when a signalling NaN is present.

All results are registered and appear one cycle after the input strobe, together with a one-cycle done pulse.

Top module: `fp_cmp_eval`

## Requirements
- R1: Predicate bit 0 selects the unordered relation, bit 1 selects equal and bit 2 selects less-than. The condition is true when at least one selected relation holds, so a predicate with bits 2:0 = 0 always gives false.
- R2: An operand is a NaN when its exponent field is all ones and its fraction is nonzero. If either operand is a NaN, the pair is unordered, and both equal and less-than are false.
- R3: Positive zero and negative zero compare equal, and neither one is less than the other.
- R4: Ordered operands compare by value. A negative value is less than a positive one. Among negative values, the larger magnitude is the smaller value. Infinities are the most extreme values of their sign. Subnormals keep their numeric order.
- R5: When predicate bit 3 is 1 (signalling compare), the invalid output is 1 whenever the operands are unordered.
- R6: When predicate bit 3 is 0 (quiet compare), the invalid output is 1 only if an operand is a signalling NaN, meaning a NaN whose most significant fraction bit is 0. Quiet NaNs, whose most significant fraction bit is 1, leave invalid at 0.
- R7: With isDouble = 0, each operand is taken from bits 31:0 in single-precision format, and bits 63:32 have no effect on the outputs. With isDouble = 1, all 64 bits are used in double-precision format.
- R8: outCcIndex equals the ccIndex presented with the strobe.
- R9: The outputs update exactly one cycle after inValid is high, and outDone is high for exactly that cycle. Without a strobe, outCond, outInvalid and outCcIndex hold their values.
- R10: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Strobe: operands and predicate are valid |
| isDouble | input | 1 | 1 = double precision, 0 = single precision in bits 31:0 |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| pred | input | 4 | Compare predicate (function code minus 48) |
| ccIndex | input | 3 | Condition-code bit index to report back |
| outDone | output | 1 | One-cycle pulse when results are updated |
| outCond | output | 1 | Compare condition result |
| outInvalid | output | 1 | Invalid-operation exception |
| outCcIndex | output | 3 | Condition-code index of this result |

## Verification
Every operand pair is run through all sixteen predicates. Each pair therefore produces a full mask-by-relation table, which separates the unordered, equal and less-than relations and shows where quiet and signalling invalid behaviour differ.

The pairs are chosen so that a wrong decision shows up as a wrong result:
- Ordered pairs in both directions, including an all-negative pair, catch a swapped magnitude sense.
- A pair of opposite-signed zeros catches any sign-dependent equality.
- Quiet and signalling NaNs on each side tell the two invalid rules apart.
- Infinities, the largest finite values and subnormals test the ordering at both ends of the range.
- Single-precision pairs with contrasting data in the upper 32 bits show whether the precision select ignores those bits.

Strobes arrive both back to back and after idle gaps, so the hold and done-pulse timing is tested in both situations.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  localparam int WORD_W  = 64;
  localparam int MAG_W   = WORD_W - 1;
  localparam int EXP_SP  = 8;
  localparam int MAN_SP  = 23;
  localparam int EXP_DP  = 11;
  localparam int MAN_DP  = 52;
  localparam int PRED_W  = 4;
  localparam int CC_W    = 3;
  localparam int NUM_OPS = 2;

  // relation bit positions inside the predicate mask
  localparam int REL_UN = 0;
  localparam int REL_EQ = 1;
  localparam int REL_LT = 2;
  localparam int SIG_BIT = 3;

  typedef struct packed {
    logic load;
  } ctrl_strobe_t;

  typedef struct packed {
    logic             nan;
    logic             snan;
    logic             zero;
    logic             sign;
    logic [MAG_W-1:0] mag;
  } fp_class_t;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
  import fpcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] word,
  output fp_class_t            cls
);
  localparam int TOP = EXP_W + MAN_W;

  logic [EXP_W-1:0] expField;
  logic [MAN_W-1:0] manField;
  logic             expAllOnes;
  logic             manNonZero;

  always_comb begin
    expField   = word[TOP-1:MAN_W];
    manField   = word[MAN_W-1:0];
    expAllOnes = &expField;
    manNonZero = |manField;
    cls.nan    = expAllOnes & manNonZero;
    cls.snan   = expAllOnes & manNonZero & ~manField[MAN_W-1];
    cls.zero   = ~|word[TOP-1:0];
    cls.sign   = word[TOP];
    cls.mag    = MAG_W'(word[TOP-1:0]);
  end
endmodule

// File: rtl/fpcmp_ctrl.sv
module fpcmp_ctrl
  import fpcmp_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  output ctrl_strobe_t strobe,
  output logic         doneQ
);
  always_comb strobe.load = inValid;

  always_ff @(posedge clk) begin
    if (!rst_n) doneQ <= 1'b0;
    else        doneQ <= inValid;
  end
endmodule

// File: rtl/fpcmp_datapath.sv
module fpcmp_datapath
  import fpcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_strobe_t      strobe,
  input  logic              isDouble,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic [PRED_W-1:0] pred,
  input  logic [CC_W-1:0]   ccIndex,
  output logic              condQ,
  output logic              invalidQ,
  output logic [CC_W-1:0]   ccQ
);
  logic [WORD_W-1:0] opWord [NUM_OPS];
  fp_class_t         clsSp  [NUM_OPS];
  fp_class_t         clsDp  [NUM_OPS];
  fp_class_t         cls    [NUM_OPS];

  always_comb begin
    opWord[0] = opA;
    opWord[1] = opB;
  end

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_operand
    fpcmp_classify #(.EXP_W(EXP_SP), .MAN_W(MAN_SP)) u_sp (
      .word(opWord[g][EXP_SP+MAN_SP:0]),
      .cls (clsSp[g])
    );
    fpcmp_classify #(.EXP_W(EXP_DP), .MAN_W(MAN_DP)) u_dp (
      .word(opWord[g][EXP_DP+MAN_DP:0]),
      .cls (clsDp[g])
    );
    always_comb cls[g] = isDouble ? clsDp[g] : clsSp[g];
  end

  logic       unordered;
  logic       bothZero;
  logic       equalRel;
  logic       lessRel;
  logic       magLess;
  logic       magGreater;
  logic [2:0] relVec;
  logic       condNext;
  logic       invalidNext;

  always_comb begin
    unordered  = cls[0].nan | cls[1].nan;
    bothZero   = cls[0].zero & cls[1].zero;
    magLess    = cls[0].mag < cls[1].mag;
    magGreater = cls[0].mag > cls[1].mag;
    equalRel   = ~unordered &
                 (bothZero | ((cls[0].sign == cls[1].sign) && (cls[0].mag == cls[1].mag)));
    if (unordered || bothZero)       lessRel = 1'b0;
    else if (cls[0].sign != cls[1].sign) lessRel = cls[0].sign;
    else if (cls[0].sign)            lessRel = magGreater;
    else                             lessRel = magLess;
    relVec             = '0;
    relVec[REL_UN]     = unordered;
    relVec[REL_EQ]     = equalRel;
    relVec[REL_LT]     = lessRel;
    condNext           = |(relVec & pred[2:0]);
    invalidNext        = (pred[SIG_BIT] & unordered) | cls[0].snan | cls[1].snan;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      condQ    <= 1'b0;
      invalidQ <= 1'b0;
      ccQ      <= '0;
    end else if (strobe.load) begin
      condQ    <= condNext;
      invalidQ <= invalidNext;
      ccQ      <= ccIndex;
    end
  end
endmodule

// File: rtl/fp_cmp_eval.sv
module fp_cmp_eval
  import fpcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic              isDouble,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic [PRED_W-1:0] pred,
  input  logic [CC_W-1:0]   ccIndex,
  output logic              outDone,
  output logic              outCond,
  output logic              outInvalid,
  output logic [CC_W-1:0]   outCcIndex
);
  ctrl_strobe_t strobe;

  fpcmp_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .inValid(inValid),
    .strobe (strobe),
    .doneQ  (outDone)
  );

  fpcmp_datapath u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .isDouble(isDouble),
    .opA     (opA),
    .opB     (opB),
    .pred    (pred),
    .ccIndex (ccIndex),
    .condQ   (outCond),
    .invalidQ(outInvalid),
    .ccQ     (outCcIndex)
  );
endmodule

// File: rtl/fpcmp_checker.sv
module fpcmp_checker
  import fpcmp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic              isDouble,
  input logic [WORD_W-1:0] opA,
  input logic [WORD_W-1:0] opB,
  input logic [PRED_W-1:0] pred,
  input logic [CC_W-1:0]   ccIndex,
  input logic              outDone,
  input logic              outCond,
  input logic              outInvalid,
  input logic [CC_W-1:0]   outCcIndex
);
  p_done_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outDone);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outDone);

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> ($stable(outCond) && $stable(outInvalid) && $stable(outCcIndex)));

  p_cc_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> (outCcIndex == $past(ccIndex)));

  p_empty_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && pred[2:0] == 3'b000) |=> !outCond);

  // signalling unordered-only predicate: condition and invalid coincide
  p_sig_unord_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && pred == 4'b1001) |=> (outCond == outInvalid));

  // identical double words are either NaN (unordered) or equal
  p_self_cmp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && isDouble && opA == opB && pred == 4'b0011) |=> outCond);
endmodule

bind fp_cmp_eval fpcmp_checker u_fpcmp_checker (.*);

// File: tb/test_fp_cmp_eval.sv
`timescale 1ns/1ps
module test_fp_cmp_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic        isDouble = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [3:0]  pred = '0;
  logic [2:0]  ccIndex = '0;
  logic        outDone;
  logic        outCond;
  logic        outInvalid;
  logic [2:0]  outCcIndex;

  int checks = 0;
  int errors = 0;
  string curTag = "R1";

  always #5 clk = ~clk;

  fp_cmp_eval i_fp_cmp_eval (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .isDouble(isDouble),
    .opA(opA), .opB(opB), .pred(pred), .ccIndex(ccIndex),
    .outDone(outDone), .outCond(outCond), .outInvalid(outInvalid),
    .outCcIndex(outCcIndex)
  );

  // ---------- behavioural reference ----------
  function automatic bit isNanW(input logic [63:0] w, input bit dbl);
    if (dbl) return (w[62:52] == 11'h7FF) && (w[51:0] != 0);
    return (w[30:23] == 8'hFF) && (w[22:0] != 0);
  endfunction

  function automatic bit isSnanW(input logic [63:0] w, input bit dbl);
    if (!isNanW(w, dbl)) return 1'b0;
    return dbl ? !w[51] : !w[22];
  endfunction

  function automatic real toReal(input logic [63:0] w, input bit dbl);
    real r;
    int  e;
    if (dbl) return $bitstoreal(w);
    e = int'(w[30:23]);
    if (e == 255)    r = $bitstoreal(64'h7FF0000000000000);
    else if (e == 0) r = real'(w[22:0]) * (2.0 ** (-149));
    else             r = (real'(w[22:0]) + 8388608.0) * (2.0 ** (e - 150));
    return w[31] ? -r : r;
  endfunction

  function automatic logic [1:0] refEval(input logic [63:0] a, input logic [63:0] b,
                                         input bit dbl, input logic [3:0] p);
    bit  un, eq, lt, c, inv;
    real ra, rb;
    un = isNanW(a, dbl) || isNanW(b, dbl);
    ra = toReal(a, dbl);
    rb = toReal(b, dbl);
    eq = !un && (ra == rb);
    lt = !un && (ra < rb);
    c  = (p[0] && un) || (p[1] && eq) || (p[2] && lt);
    inv = (p[3] && un) || isSnanW(a, dbl) || isSnanW(b, dbl);
    return {c, inv};
  endfunction

  logic       expDone = 0, expCond = 0, expInv = 0;
  logic [2:0] expCc = 0;
  string      expTag = "R10";

  always @(posedge clk) begin
    if (!rst_n) begin
      expDone <= 0; expCond <= 0; expInv <= 0; expCc <= 0;
    end else begin
      expDone <= inValid;
      if (inValid) begin
        {expCond, expInv} <= refEval(opA, opB, isDouble, pred);
        expCc  <= ccIndex;
        expTag <= curTag;
      end
    end
  end

  task automatic cmpOne(input string tag, input string what, input logic [2:0] act,
                        input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (pred=%0h dbl=%0b a=%h b=%h)",
               tag, what, act, exp, pred, isDouble, opA, opB);
    end
  endtask

  always @(negedge clk) begin
    string t;
    if (!rst_n) t = "R10";
    else if (expDone) t = expTag;
    else t = "R9";
    cmpOne(t, "done", {2'b0, outDone}, {2'b0, expDone});
    cmpOne(t, "cond", {2'b0, outCond}, {2'b0, expCond});
    cmpOne(t, "invalid", {2'b0, outInvalid}, {2'b0, expInv});
    cmpOne(expDone ? "R8" : t, "ccIndex", outCcIndex, expCc);
  end

  // ---------- stimulus ----------
  task automatic apply(input logic [63:0] a, input logic [63:0] b, input bit dbl,
                       input logic [3:0] p, input logic [2:0] cc, input string tag);
    @(negedge clk); #2;
    inValid = 1; opA = a; opB = b; isDouble = dbl; pred = p; ccIndex = cc; curTag = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #2;
      inValid = 0;
      opA = {$urandom, $urandom}; opB = {$urandom, $urandom};
      pred = 4'($urandom); ccIndex = 3'($urandom);
    end
  endtask

  task automatic sweep(input logic [63:0] a, input logic [63:0] b, input bit dbl,
                       input string tag);
    for (int p = 0; p < 16; p++) begin
      apply(a, b, dbl, 4'(p), 3'(p + 3), tag);
      if (p % 5 == 0) idle(1);
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);   // reset state checked: R10
    #2 rst_n = 1;
    idle(2);
    // R1 R4: ordered doubles both directions
    sweep(64'h3FF0000000000000, 64'h4000000000000000, 1, "R1");
    sweep(64'h4000000000000000, 64'h3FF0000000000000, 1, "R4");
    sweep(64'hC008000000000000, 64'hC000000000000000, 1, "R4");
    sweep(64'h3FF0000000000000, 64'h3FF0000000000000, 1, "R1");
    // R3 signed zeros
    sweep(64'h0000000000000000, 64'h8000000000000000, 1, "R3");
    sweep(64'h0000000080000000, 64'hFFFF000000000000, 0, "R3");
    // R2 R5 R6 NaNs
    sweep(64'h7FF8000000000000, 64'h3FF0000000000000, 1, "R2");
    sweep(64'h3FF0000000000000, 64'h7FF0000000000001, 1, "R6");
    sweep(64'h000000007FC00000, 64'h000000003F800000, 0, "R5");
    sweep(64'h000000007F800001, 64'h000000007FC00000, 0, "R6");
    // R4 infinities, extremes, subnormals
    sweep(64'hFFF0000000000000, 64'hFFEFFFFFFFFFFFFF, 1, "R4");
    sweep(64'h7FF0000000000000, 64'h7FEFFFFFFFFFFFFF, 1, "R4");
    sweep(64'h0000000000000001, 64'h0000000000000000, 1, "R4");
    sweep(64'h00000000807FFFFF, 64'h0000000080000001, 0, "R4");
    sweep(64'h000000007F800000, 64'h000000007F7FFFFF, 0, "R4");
    // R7 single precision with junk in the upper half
    sweep(64'h7FF8000BBFC00000, 64'hFFF000003F800000, 0, "R7");
    sweep(64'h3FF0000040000000, 64'h400000003F800000, 0, "R7");
    idle(3);
    for (int k = 0; k < 8; k++) apply(64'h4000000000000000, 64'h3FF0000000000000, 1,
                                      4'(k * 2), 3'(k), "R8");
    idle(4);
    finishRun();
  end
endmodule